// File: doc/BRIEF.md
# Programmable Bus Wait-State Generator

This block holds a CPU bus cycle open for a programmed number of wait clocks. An 8-bit control register carries two independent 2-bit wait codes: one for memory cycles and one shared by external I/O cycles and interrupt-0 acknowledge cycles, each of which reads it through its own count table. When a cycle starts, the block picks the count for the cycle type, loads it into a down-counter and raises `stretch` until the count has run out. An active-low external wait request can keep the cycle open for longer.

Accesses that hit the on-chip register block take no programmed waits. The external wait request is only looked at once the programmed count has run out, so a slow device can lengthen a cycle but never shorten it. The sequencer has three states. `ST_IDLE` means no cycle is open. `ST_COUNT` means programmed waits are still counting down. `ST_HOLD` means the count has run out but the external wait request is still low.

The transitions are as follows:
- `ST_IDLE` moves to `ST_COUNT` on a start with a nonzero count.
- `ST_IDLE` moves to `ST_HOLD` on a start with a zero count while the wait request is low.
- `ST_IDLE` stays in `ST_IDLE` on a start with a zero count while the wait request is high.
- `ST_COUNT` moves to `ST_IDLE` on its last count when the wait request is high.
- `ST_COUNT` moves to `ST_HOLD` on its last count when the wait request is low.
- `ST_HOLD` moves to `ST_IDLE` when the wait request goes high.

Top module: `wait_stretch_gen`

## Requirements
- R1: After reset the register reads 8'hF0: memory code (bits 7:6) = 11 and I/O code (bits 5:4) = 11. A write with `reg_wr` high stores `reg_wdata` at that clock edge. `reg_rdata` shows the stored value, and bits 3:0 read back unchanged.
- R2: A memory cycle (`cyc_kind` 2'b00) gets N = 0, 1, 2, 3 waits for memory codes 00, 01, 10, 11. The reserved kind 2'b11 is timed the same way as a memory cycle.
- R3: An external I/O cycle (`cyc_kind` 2'b01) gets N = 1, 2, 3, 4 waits for I/O codes 00, 01, 10, 11.
- R4: An interrupt-0 acknowledge cycle (`cyc_kind` 2'b10) gets N = 2, 4, 5, 6 waits for I/O codes 00, 01, 10, 11.
- R5: When `int_hit` is high at the start, N = 0 whatever the cycle kind and the register hold.
- R6: Number the start clock edge as edge 0. The stretch lasts L cycles, where L is the smallest j ≥ N such that `ext_wait_n` is high at edge j. A low request before edge N has no effect of its own.
- R7: `stretch` rises right after edge 0, stays high for exactly L consecutive cycles, and is never high without a start.
- R8: A `cyc_start` pulse while `stretch` is high is ignored and does not change the length of the open cycle.
- R9: The count is fixed at the start edge. A register write during the cycle affects only later cycles.
- R10: A low `ext_wait_n` while no cycle is open does not raise `stretch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| cyc_start | input | 1 | One-clock pulse marking the start of a bus cycle |
| cyc_kind | input | 2 | Cycle type: 00 memory, 01 external I/O, 10 interrupt-0 acknowledge, 11 reserved (timed as memory) |
| int_hit | input | 1 | The cycle addresses the on-chip register block |
| ext_wait_n | input | 1 | Active-low external wait request |
| stretch | output | 1 | High while the bus cycle must be held |

## Verification
The hardest case to reach is a wait request that shows up only after the programmed count has already been used up inside an open cycle. It must then move the sequencer from `ST_COUNT` into `ST_HOLD` exactly on the last count. The bench drives the wait request edge by edge from a window (first low edge, first high edge) set against the start edge. This lets it place the request before the count, across the boundary, and wholly after it. It also places a restart pulse and a register write in the middle of a cycle, at chosen edges.

// File: rtl/wsg_pkg.sv
package wsg_pkg;

    typedef enum logic [1:0] {
        KIND_MEM    = 2'b00,
        KIND_EXTIO  = 2'b01,
        KIND_INTACK = 2'b10,
        KIND_RSV    = 2'b11
    } cyc_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_COUNT = 2'b01,
        ST_HOLD  = 2'b10
    } seq_state_e;

    // Wait clocks for a memory cycle, by code
    function automatic int unsigned mem_waits(input logic [1:0] code);
        return int'(code);
    endfunction

    // Wait clocks for an external I/O cycle, by code
    function automatic int unsigned io_waits(input logic [1:0] code);
        return int'(code) + 1;
    endfunction

    // Wait clocks for an interrupt-0 acknowledge, by code
    function automatic int unsigned ack_waits(input logic [1:0] code);
        int unsigned r;
        unique case (code)
            2'b00:   r = 2;
            2'b01:   r = 4;
            2'b10:   r = 5;
            default: r = 6;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/wsg_ctrl_reg.sv
module wsg_ctrl_reg #(
    parameter int REG_W = 8,
    parameter logic [REG_W-1:0] RST_VAL = 8'hF0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic [1:0]       mem_code,
    output logic [1:0]       io_code
);
    localparam int MEM_LSB = REG_W - 2;
    localparam int IO_LSB  = REG_W - 4;

    logic [REG_W-1:0] ctl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= RST_VAL;
        end else if (wr) begin
            ctl_q <= wdata;
        end
    end

    assign rdata    = ctl_q;
    assign mem_code = ctl_q[MEM_LSB +: 2];
    assign io_code  = ctl_q[IO_LSB +: 2];
endmodule

// File: rtl/wsg_count_sel.sv
module wsg_count_sel #(
    parameter int CNT_W = 3
) (
    input  logic [1:0]       kind,
    input  logic             int_hit,
    input  logic [1:0]       mem_code,
    input  logic [1:0]       io_code,
    output logic [CNT_W-1:0] load_val
);
    import wsg_pkg::*;

    localparam int CODES = 4;

    logic [CNT_W-1:0] mem_tbl [CODES];
    logic [CNT_W-1:0] io_tbl  [CODES];
    logic [CNT_W-1:0] ack_tbl [CODES];

    for (genvar i = 0; i < CODES; i++) begin : g_tbl
        assign mem_tbl[i] = CNT_W'(mem_waits(2'(i)));
        assign io_tbl[i]  = CNT_W'(io_waits(2'(i)));
        assign ack_tbl[i] = CNT_W'(ack_waits(2'(i)));
    end

    cyc_kind_e kind_e;
    assign kind_e = cyc_kind_e'(kind);

    always_comb begin
        if (int_hit) begin
            load_val = '0;
        end else begin
            unique case (kind_e)
                KIND_EXTIO:  load_val = io_tbl[io_code];
                KIND_INTACK: load_val = ack_tbl[io_code];
                KIND_MEM,
                KIND_RSV:    load_val = mem_tbl[mem_code];
                default:     load_val = mem_tbl[mem_code];
            endcase
        end
    end
endmodule

// File: rtl/wsg_sequencer.sv
module wsg_sequencer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] load_val,
    input  logic             ext_wait_n,
    output logic             stretch
);
    import wsg_pkg::*;

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (load_val != '0) begin
                        state_d = ST_COUNT;
                        cnt_d   = load_val;
                    end else if (!ext_wait_n) begin
                        state_d = ST_HOLD;
                    end
                end
            end
            ST_COUNT: begin
                cnt_d = cnt_q - CNT_ONE;
                if (cnt_q == CNT_ONE) begin
                    state_d = ext_wait_n ? ST_IDLE : ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (ext_wait_n) state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_COUNT, ST_HOLD: stretch = 1'b1;
            default:           stretch = 1'b0;
        endcase
    end
endmodule

// File: rtl/wait_stretch_gen.sv
module wait_stretch_gen #(
    parameter int REG_W = 8,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             cyc_start,
    input  logic [1:0]       cyc_kind,
    input  logic             int_hit,
    input  logic             ext_wait_n,
    output logic             stretch
);
    localparam logic [REG_W-1:0] CTL_RST = REG_W'(8'hF0);

    logic [1:0]       mem_code, io_code;
    logic [CNT_W-1:0] load_val;

    wsg_ctrl_reg #(.REG_W(REG_W), .RST_VAL(CTL_RST)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .mem_code (mem_code),
        .io_code  (io_code)
    );

    wsg_count_sel #(.CNT_W(CNT_W)) u_sel (
        .kind     (cyc_kind),
        .int_hit  (int_hit),
        .mem_code (mem_code),
        .io_code  (io_code),
        .load_val (load_val)
    );

    wsg_sequencer #(.CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (cyc_start),
        .load_val   (load_val),
        .ext_wait_n (ext_wait_n),
        .stretch    (stretch)
    );
endmodule

// File: rtl/wsg_checker.sv
module wsg_checker #(
    parameter int REG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] reg_rdata,
    input logic             cyc_start,
    input logic [1:0]       cyc_kind,
    input logic             int_hit,
    input logic             ext_wait_n,
    input logic             stretch
);
    // R1
    reg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (reg_rdata == $past(reg_wdata)));

    // R1
    reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(reg_rdata));

    // R2
    mem_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && !stretch && !int_hit && ext_wait_n && cyc_kind == 2'b00
         && reg_rdata[REG_W-1 -: 2] == 2'b00) |=> !stretch);

    // R3
    io_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && !stretch && !int_hit && cyc_kind == 2'b01) |=> stretch);

    // R5
    hit_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && !stretch && int_hit && ext_wait_n) |=> !stretch);

    // R6
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stretch) |-> $past(ext_wait_n));

    // R7
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stretch && !cyc_start) |=> !stretch);
endmodule

bind wait_stretch_gen wsg_checker #(.REG_W(REG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .cyc_start  (cyc_start),
    .cyc_kind   (cyc_kind),
    .int_hit    (int_hit),
    .ext_wait_n (ext_wait_n),
    .stretch    (stretch)
);

// File: tb/wait_stretch_gen_test.sv
`timescale 1ns/1ps
module wait_stretch_gen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       cyc_start = 1'b0;
    logic [1:0] cyc_kind = 2'b00;
    logic       int_hit = 1'b0;
    logic       ext_wait_n = 1'b1;
    logic       stretch;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    logic [7:0] shadow = 8'hF0;

    typedef struct {
        int    len;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    wait_stretch_gen uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cyc_start(cyc_start), .cyc_kind(cyc_kind),
        .int_hit(int_hit), .ext_wait_n(ext_wait_n), .stretch(stretch)
    );

    // Expected programmed count, from the requirement tables
    function automatic int exp_n(input logic [1:0] kind, input logic hit, input logic [7:0] rv);
        int r;
        if (hit) return 0;                               // R5
        case (kind)
            2'b01: r = int'(rv[5:4]) + 1;                // R3
            2'b10: case (rv[5:4])                        // R4
                       2'b00: r = 2;
                       2'b01: r = 4;
                       2'b10: r = 5;
                       default: r = 6;
                   endcase
            default: r = int'(rv[7:6]);                  // R2
        endcase
        return r;
    endfunction

    function automatic bit ext_low(input int j, input int kf, input int kt);
        return (j >= kf) && (j < kt);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
        shadow = v;
        check("R1 readback", int'(reg_rdata), int'(v));
    endtask

    // Driver: one bus cycle; wait request low for edges kf..kt-1
    task automatic run_cyc(input logic [1:0] kind, input logic hit, input int kf, input int kt,
                           input int rs_at, input int wr_at, input logic [7:0] wv, input string tag);
        int n, l, j;
        exp_t e;
        n = exp_n(kind, hit, shadow);
        l = n;
        while (ext_low(l, kf, kt)) l++;                  // R6
        e.len = l;
        e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
        cyc_kind   = kind;
        int_hit    = hit;
        cyc_start  = 1'b1;
        ext_wait_n = !ext_low(0, kf, kt);
        for (j = 1; j <= l + 3; j++) begin
            @(negedge clk);
            cyc_start  = (j == rs_at);                   // R8
            ext_wait_n = !ext_low(j, kf, kt);
            reg_wr     = (j == wr_at);                   // R9
            reg_wdata  = wv;
            if (j == wr_at) shadow = wv;
        end
        @(negedge clk);
        cyc_start  = 1'b0;
        ext_wait_n = 1'b1;
        reg_wr     = 1'b0;
        int_hit    = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Monitor: measure each stretch and compare with the scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && cyc_start) begin
                int len;
                exp_t e;
                len = 0;
                while (stretch) begin
                    len++;
                    @(posedge clk);
                    #2;
                end
                if (sb_q.size() == 0) begin
                    check("R7 unexpected cycle", len, -1);
                end else begin
                    e = sb_q.pop_front();
                    check(e.tag, len, e.len);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset value", int'(reg_rdata), 8'hF0);
        check("R7 reset stretch", int'(stretch), 0);

        for (int c = 0; c < 4; c++) begin
            wr_reg({2'(c), 2'(3 - c), 4'hA});
            run_cyc(2'b00, 1'b0, 0, 0, 0, 0, 8'h00, "R2 memory");
            run_cyc(2'b11, 1'b0, 0, 0, 0, 0, 8'h00, "R2 reserved kind");
            run_cyc(2'b01, 1'b0, 0, 0, 0, 0, 8'h00, "R3 external io");
            run_cyc(2'b10, 1'b0, 0, 0, 0, 0, 8'h00, "R4 int ack");
            wr_reg({2'(3 - c), 2'(c), 4'h5});
            run_cyc(2'b01, 1'b0, 0, 0, 0, 0, 8'h00, "R3 external io");
            run_cyc(2'b10, 1'b0, 0, 0, 0, 0, 8'h00, "R4 int ack");
        end

        wr_reg(8'hF3);
        run_cyc(2'b01, 1'b1, 0, 0, 0, 0, 8'h00, "R5 io hit");
        run_cyc(2'b10, 1'b1, 0, 0, 0, 0, 8'h00, "R5 ack hit");
        run_cyc(2'b00, 1'b1, 0, 0, 0, 0, 8'h00, "R5 memory hit");
        run_cyc(2'b01, 1'b1, 0, 3, 0, 0, 8'h00, "R6 hit with wait");

        wr_reg(8'hB0);   // memory code 10, io code 11
        run_cyc(2'b00, 1'b0, 0, 5, 0, 0, 8'h00, "R6 wait past count");
        run_cyc(2'b00, 1'b0, 0, 2, 0, 0, 8'h00, "R6 wait inside count");
        run_cyc(2'b00, 1'b0, 2, 4, 0, 0, 8'h00, "R6 wait across boundary");
        wr_reg(8'h00);   // memory code 00, io code 00
        run_cyc(2'b01, 1'b0, 1, 4, 0, 0, 8'h00, "R6 wait after count expired");
        run_cyc(2'b00, 1'b0, 0, 2, 0, 0, 8'h00, "R6 zero count with wait");
        run_cyc(2'b00, 1'b0, 1, 3, 0, 0, 8'h00, "R6 zero count late wait");

        wr_reg(8'h30);   // io code 11
        run_cyc(2'b10, 1'b0, 0, 0, 2, 0, 8'h00, "R8 restart ignored");
        run_cyc(2'b01, 1'b0, 0, 0, 0, 1, 8'h00, "R9 write mid cycle");
        check("R9 write landed", int'(reg_rdata), 8'h00);
        run_cyc(2'b01, 1'b0, 0, 0, 0, 0, 8'h00, "R9 next cycle new code");

        @(negedge clk);
        ext_wait_n = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check("R10 idle wait", int'(stretch), 0);
        end
        ext_wait_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R7 scoreboard drained", sb_q.size(), 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule